// File: doc/BRIEF.md
# Trap and Return Exception Controller

This block holds the exception-related system state of a 32-bit processor core and applies the state changes for software traps, returns from handlers, interrupt masking and halting. The state it holds is the status word (PSW), an exception save pair (return PC and saved PSW), a non-maskable save pair (return PC and saved PSW), and a cause register. The pipeline sends it one command at a time. For a trap or a return, the block answers with a single-cycle redirect that carries the new fetch address.

Commands enter on a valid/ready handshake. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while the controller is halted, and the issuer must then hold its command until ready returns. The redirect output has no back-pressure: the fetch unit must take `redir_pc` in the cycle when `redir_valid` is high. A plain load port writes any of the six held registers. It stands in for the core's system-register path, so that software and interrupt logic can set the save pairs and status bits.

PSW bit positions used by the block: bit 5 is interrupt-disable (ID), bit 6 is exception-in-progress (EP), and bit 7 is NMI-in-progress (NP). All other PSW bits are carried through unchanged.

Top module: `trap_ret_ctl`

## Requirements
- R1: After reset, the PSW reads 0x0000_0020 (only ID set). The cause register, both save pairs and the redirect output read zero, `halted_o` is low and `cmd_ready` is high.
- R2: An accepted trap command (op code 0) writes `cmd_pc + 4` into the exception return PC and the PSW value from before the trap into the exception saved PSW.
- R3: An accepted trap writes 0x40 plus the 5-bit vector into cause bits 15:0 and leaves cause bits 31:16 unchanged.
- R4: After an accepted trap, PSW bits EP and ID are set and every other PSW bit keeps its earlier value.
- R5: A trap to a vector from 0 to 15 redirects to 0x40. A trap to a vector from 16 to 31 redirects to 0x50.
- R6: An accepted return command (op code 1) with NP=1 and EP=0 redirects to the NMI return PC and loads the PSW from the NMI saved PSW.
- R7: An accepted return in any other NP/EP combination redirects to the exception return PC and loads the PSW from the exception saved PSW.
- R8: The disable command (op code 2) sets PSW.ID and the enable command (op code 3) clears it. Neither one produces a redirect.
- R9: The halt command (op code 4) raises `halted_o` and drops `cmd_ready`. A command offered while halted changes no state and gives no redirect. A `nmi_wake` pulse ends the halted state.
- R10: With `ld_en` high and no command accepted in that cycle, `ld_data` is written to the register that `ld_sel` picks (0 exception PC, 1 exception PSW, 2 NMI PC, 3 NMI PSW, 4 cause, 5 PSW). A load in the same cycle as an accepted command is ignored.
- R11: `redir_valid` rises in the cycle after an accepted trap or return and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (low while halted) |
| cmd_op | input | 3 | 0 trap, 1 return, 2 disable, 3 enable, 4 halt |
| cmd_pc | input | 32 | Address of the trap instruction |
| cmd_vec | input | 5 | Trap vector |
| nmi_wake | input | 1 | Non-maskable event that ends the halted state |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register picked for the load |
| ld_data | input | 32 | Load value |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | New fetch address |
| psw_o | output | 32 | Status word |
| epc_o | output | 32 | Exception return PC |
| epsw_o | output | 32 | Exception saved PSW |
| fepc_o | output | 32 | NMI return PC |
| fepsw_o | output | 32 | NMI saved PSW |
| cause_o | output | 32 | Cause register |
| halted_o | output | 1 | Controller halted |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit vector with the handler split at 16, a cause base of 0x40 and handler addresses 0x40 and 0x50. With these values it can reach both handler addresses and both edges of the split (vectors 15 and 16), the top vector 31, and all four NP/EP combinations on return. It also reaches a cause register whose upper half holds nonzero data, which shows whether that half is preserved.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    OP_TRAP = 3'd0,
    OP_RETI = 3'd1,
    OP_DI   = 3'd2,
    OP_EI   = 3'd3,
    OP_HALT = 3'd4
  } trc_op_e;

  typedef enum logic [2:0] {
    SR_EPC   = 3'd0,
    SR_EPSW  = 3'd1,
    SR_FEPC  = 3'd2,
    SR_FEPSW = 3'd3,
    SR_CAUSE = 3'd4,
    SR_PSW   = 3'd5
  } trc_sel_e;

  localparam int PB_ID = 5;
  localparam int PB_EP = 6;
  localparam int PB_NP = 7;
endpackage

// File: rtl/trc_trap_calc.sv
module trc_trap_calc #(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 5,
  parameter int CAUSE_W    = 16,
  parameter int CAUSE_BASE = 'h40,
  parameter int VEC_SPLIT  = 16,
  parameter int HANDLER_LO = 'h40,
  parameter int HANDLER_HI = 'h50
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  psw,
  input  logic [XLEN-1:0]  cause,
  output logic [XLEN-1:0]  epc_n,
  output logic [XLEN-1:0]  psw_n,
  output logic [XLEN-1:0]  cause_n,
  output logic [XLEN-1:0]  target
);
  import trc_pkg::*;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [CAUSE_W-1:0] code;

  always_comb begin
    code    = CAUSE_W'(CAUSE_BASE) + CAUSE_W'(vec);
    epc_n   = pc + INSN_BYTES;
    cause_n = {cause[XLEN-1:CAUSE_W], code};
    psw_n   = psw;
    psw_n[PB_EP] = 1'b1;
    psw_n[PB_ID] = 1'b1;
    target  = (int'(vec) < VEC_SPLIT) ? XLEN'(HANDLER_LO) : XLEN'(HANDLER_HI);
  end
endmodule

// File: rtl/trc_ret_sel.sv
module trc_ret_sel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] psw,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] epsw,
  input  logic [XLEN-1:0] fepc,
  input  logic [XLEN-1:0] fepsw,
  output logic [XLEN-1:0] pc_n,
  output logic [XLEN-1:0] psw_n
);
  import trc_pkg::*;

  logic use_nmi;

  always_comb begin
    use_nmi = psw[PB_NP] && !psw[PB_EP];
    pc_n    = use_nmi ? fepc  : epc;
    psw_n   = use_nmi ? fepsw : epsw;
  end
endmodule

// File: rtl/trc_halt_ctl.sv
module trc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic wake,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (!rst_n)              halted <= 1'b0;
    else if (halted && wake) halted <= 1'b0;
    else if (halt_req)       halted <= 1'b1;
  end
endmodule

// File: rtl/trap_ret_ctl.sv
module trap_ret_ctl #(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 5,
  parameter int CAUSE_BASE = 'h40,
  parameter int VEC_SPLIT  = 16,
  parameter int HANDLER_LO = 'h40,
  parameter int HANDLER_HI = 'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [XLEN-1:0]  cmd_pc,
  input  logic [VEC_W-1:0] cmd_vec,
  input  logic             nmi_wake,
  input  logic             ld_en,
  input  logic [2:0]       ld_sel,
  input  logic [XLEN-1:0]  ld_data,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc,
  output logic [XLEN-1:0]  psw_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  epsw_o,
  output logic [XLEN-1:0]  fepc_o,
  output logic [XLEN-1:0]  fepsw_o,
  output logic [XLEN-1:0]  cause_o,
  output logic             halted_o
);
  import trc_pkg::*;
  localparam int CAUSE_W = XLEN / 2;
  localparam logic [XLEN-1:0] PSW_RST = XLEN'(1) << PB_ID;

  logic            accept;
  trc_op_e         op;
  logic [XLEN-1:0] t_epc, t_psw, t_cause, t_target;
  logic [XLEN-1:0] r_pc, r_psw;

  assign cmd_ready = !halted_o;
  assign accept    = cmd_valid && cmd_ready;
  assign op        = trc_op_e'(cmd_op);

  trc_trap_calc #(
    .XLEN(XLEN), .VEC_W(VEC_W), .CAUSE_W(CAUSE_W), .CAUSE_BASE(CAUSE_BASE),
    .VEC_SPLIT(VEC_SPLIT), .HANDLER_LO(HANDLER_LO), .HANDLER_HI(HANDLER_HI)
  ) u_trap (
    .pc(cmd_pc), .vec(cmd_vec), .psw(psw_o), .cause(cause_o),
    .epc_n(t_epc), .psw_n(t_psw), .cause_n(t_cause), .target(t_target)
  );

  trc_ret_sel #(.XLEN(XLEN)) u_ret (
    .psw(psw_o), .epc(epc_o), .epsw(epsw_o), .fepc(fepc_o), .fepsw(fepsw_o),
    .pc_n(r_pc), .psw_n(r_psw)
  );

  trc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n),
    .halt_req(accept && op == OP_HALT),
    .wake(nmi_wake),
    .halted(halted_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_o       <= PSW_RST;
      epc_o       <= '0;
      epsw_o      <= '0;
      fepc_o      <= '0;
      fepsw_o     <= '0;
      cause_o     <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= 1'b0;
      if (accept) begin
        case (op)
          OP_TRAP: begin
            epc_o       <= t_epc;
            epsw_o      <= psw_o;
            cause_o     <= t_cause;
            psw_o       <= t_psw;
            redir_valid <= 1'b1;
            redir_pc    <= t_target;
          end
          OP_RETI: begin
            psw_o       <= r_psw;
            redir_valid <= 1'b1;
            redir_pc    <= r_pc;
          end
          OP_DI:   psw_o[PB_ID] <= 1'b1;
          OP_EI:   psw_o[PB_ID] <= 1'b0;
          default: ;
        endcase
      end else if (ld_en) begin
        case (trc_sel_e'(ld_sel))
          SR_EPC:   epc_o   <= ld_data;
          SR_EPSW:  epsw_o  <= ld_data;
          SR_FEPC:  fepc_o  <= ld_data;
          SR_FEPSW: fepsw_o <= ld_data;
          SR_CAUSE: cause_o <= ld_data;
          SR_PSW:   psw_o   <= ld_data;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trc_ctrl_chk.sv
module trc_ctrl_chk #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [VEC_W-1:0] cmd_vec,
  input logic             redir_valid,
  input logic [XLEN-1:0]  psw,
  input logic [XLEN-1:0]  cause,
  input logic             halted
);
  import trc_pkg::*;

  logic took_trap, took_ret, took_di;
  assign took_trap = cmd_valid && cmd_ready && cmd_op == OP_TRAP;
  assign took_ret  = cmd_valid && cmd_ready && cmd_op == OP_RETI;
  assign took_di   = cmd_valid && cmd_ready && cmd_op == OP_DI;

  // R11
  redir_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(took_trap || took_ret));

  // R11
  redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  // R4
  trap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_trap |=> psw[PB_EP] && psw[PB_ID]);

  // R3
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_trap |=> cause[7:0] == 8'h40 + 8'($past(cmd_vec)));

  // R8
  di_sets_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_di |=> psw[PB_ID]);

  // R9
  halt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !cmd_ready);
endmodule

bind trap_ret_ctl trc_ctrl_chk #(.XLEN(XLEN), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_vec(cmd_vec), .redir_valid(redir_valid),
  .psw(psw_o), .cause(cause_o), .halted(halted_o)
);

// File: tb/trap_ret_ctl_tb.sv
`timescale 1ns/1ps
module trap_ret_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_pc = '0;
  logic [4:0]  cmd_vec = '0;
  logic        nmi_wake = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic        redir_valid;
  logic [31:0] redir_pc, psw_o, epc_o, epsw_o, fepc_o, fepsw_o, cause_o;
  logic        halted_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  logic        prev_redir = 1'b0;

  always #5 clk = ~clk;

  trap_ret_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_vec(cmd_vec), .nmi_wake(nmi_wake),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .psw_o(psw_o),
    .epc_o(epc_o), .epsw_o(epsw_o), .fepc_o(fepc_o), .fepsw_o(fepsw_o),
    .cause_o(cause_o), .halted_o(halted_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected redirect targets
  always @(negedge clk) begin
    if (rst_n) begin
      if (redir_valid) begin
        if (exp_q.size() == 0) chk("R11 unexpected redirect", redir_pc, 32'hxxxx_xxxx);
        else chk("R5/R6/R7 redirect target", redir_pc, exp_q.pop_front());
        chk("R11 single-cycle redirect", {31'd0, prev_redir}, 32'd0);
      end
      prev_redir <= redir_valid;
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] pc,
                        input logic [4:0] vec, input logic [31:0] tgt, input bit has_tgt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_vec = vec;
    if (has_tgt) exp_q.push_back(tgt);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_ld(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 psw", psw_o, 32'h20);
    chk("R1 cause", cause_o, 32'h0);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 fepsw", fepsw_o, 32'h0);
    chk("R1 ready/halted/redir", {29'd0, cmd_ready, halted_o, redir_valid}, 32'h4);

    // R10 loads
    do_ld(3'd4, 32'hABCD_1234);
    do_ld(3'd5, 32'h0000_000F);
    chk("R10 cause load", cause_o, 32'hABCD_1234);
    chk("R10 psw load", psw_o, 32'h0000_000F);

    // R2 R3 R4 R5 trap low vector
    do_cmd(3'd0, 32'h1000, 5'd3, 32'h40, 1'b1);
    chk("R2 epc", epc_o, 32'h1004);
    chk("R2 epsw", epsw_o, 32'h0F);
    chk("R3 cause", cause_o, 32'hABCD_0043);
    chk("R4 psw", psw_o, 32'h6F);
    @(negedge clk);
    chk("R11 redirect dropped", {31'd0, redir_valid}, 32'd0);

    // R5 split boundaries
    do_cmd(3'd0, 32'h2000, 5'd15, 32'h40, 1'b1);
    chk("R3 cause vec15", cause_o, 32'hABCD_004F);
    do_cmd(3'd0, 32'h2100, 5'd16, 32'h50, 1'b1);
    chk("R3 cause vec16", cause_o, 32'hABCD_0050);
    do_cmd(3'd0, 32'h3000, 5'd31, 32'h50, 1'b1);
    chk("R3 cause vec31", cause_o, 32'hABCD_005F);
    chk("R2 epc vec31", epc_o, 32'h3004);

    // R7 EP set, NP clear
    do_ld(3'd1, 32'h11);
    do_cmd(3'd1, 32'h0, 5'd0, 32'h3004, 1'b1);
    chk("R7 psw from exception pair", psw_o, 32'h11);

    // R6 NP only
    do_ld(3'd2, 32'h8000);
    do_ld(3'd3, 32'h22);
    do_ld(3'd5, 32'h80);
    do_cmd(3'd1, 32'h0, 5'd0, 32'h8000, 1'b1);
    chk("R6 psw from nmi pair", psw_o, 32'h22);

    // R7 NP and EP both set
    do_ld(3'd0, 32'h9000);
    do_ld(3'd1, 32'h33);
    do_ld(3'd5, 32'hC0);
    do_cmd(3'd1, 32'h0, 5'd0, 32'h9000, 1'b1);
    chk("R7 psw with NP+EP", psw_o, 32'h33);

    // R7 NP and EP both clear
    do_ld(3'd5, 32'h0);
    do_cmd(3'd1, 32'h0, 5'd0, 32'h9000, 1'b1);
    chk("R7 psw with none", psw_o, 32'h33);

    // R8 disable / enable
    do_ld(3'd5, 32'h0);
    do_cmd(3'd2, 32'h0, 5'd0, 32'h0, 1'b0);
    chk("R8 disable sets ID", psw_o, 32'h20);
    do_cmd(3'd3, 32'h0, 5'd0, 32'h0, 1'b0);
    chk("R8 enable clears ID", psw_o, 32'h00);

    // R10 load ignored when a command is accepted
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'd5; ld_data = 32'hFF;
    cmd_valid = 1'b1; cmd_op = 3'd2;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0; cmd_valid = 1'b0;
    chk("R10 load lost to command", psw_o, 32'h20);

    // R9 halt
    do_cmd(3'd4, 32'h0, 5'd0, 32'h0, 1'b0);
    chk("R9 halted", {30'd0, halted_o, cmd_ready}, 32'h2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_pc = 32'h7000; cmd_vec = 5'd1;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 cause untouched while halted", cause_o, 32'hABCD_005F);
    chk("R9 epc untouched while halted", epc_o, 32'h9000);
    @(negedge clk);
    nmi_wake = 1'b1;
    @(negedge clk);
    nmi_wake = 1'b0;
    chk("R9 woken", {30'd0, halted_o, cmd_ready}, 32'h1);

    repeat (3) @(negedge clk);
    chk("R11 all redirects seen", exp_q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule